// File: doc/BRIEF.md
# Truncated Third-Order MASH Delta-Sigma Modulator

This block produces the per-reference-cycle modulus offset for a fractional-N divider. A 24-bit fractional word sets the target. Each time the divider takes a sample, the block emits a small signed offset. The divider adds that offset to its integer modulus, and over many cycles the offsets average to the fraction divided by 2^24.

The core is a cascade of three first-order accumulators. Their carries are recombined through a difference network that cancels the quantization error of the earlier stages. Area is saved by making the later stages narrower. The first accumulator holds 24 bits. The second adds only the upper 16 bits of the first stage's new residue. The third adds only the upper 8 bits of the second stage's new residue.

Both interfaces use valid/ready. The fraction input is always ready, so any word offered with `frac_valid` is taken at that edge. On the offset output, `mod_ready` low is back-pressure: all modulator state freezes and the presented offset is held until the consumer is ready again. A parameter selects whether the modulator registers on the rising or the falling clock edge.

Top module: `mash111_trunc`

## Requirements
- R1: A synchronous reset (`rst_n` low at a clock edge) clears the fraction register, all three accumulators and all carry delay registers. While held in reset, `mod_off` reads 0 and `mod_valid` reads 0.
- R2: `frac_ready` is always 1. A word presented with `frac_valid` high is stored at that edge. It is first used by the advance on the following edge, and the advance on the load edge still uses the previous fraction.
- R3: `mod_off` is 4-bit two's complement. It always lies in −3..+4, which is encodings 0..4 and 13..15.
- R4: On each advance, stage 1 adds the fraction to its 24-bit accumulator, giving carry c1. Stage 2 adds bits [23:8] of stage 1's new sum to its 16-bit accumulator, giving c2. Stage 3 adds bits [15:8] of stage 2's new sum to its 8-bit accumulator, giving c3. The registered output is c1 + c2 − c2' + c3 − 2·c3' + c3'', where ' and '' are the values from one and two advances earlier.
- R5: With a fraction of 0 from reset, every offset is 0.
- R6: For a constant fraction from reset, the sum of the first 4096 offsets, divided by 4096, lies within 2^-8 of fraction/2^24.
- R7: An advance occurs at every active edge where `mod_ready` is 1. When `mod_ready` is 0, `mod_off` and all accumulator and delay state hold unchanged.
- R8: `mod_valid` rises at the first advance after reset and then stays 1 until the next reset.
- R9: A fraction loaded while the output is stalled is accepted. The first advance after the stall uses the new fraction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frac_valid | input | 1 | Fraction word offered |
| frac_ready | output | 1 | Fraction word accepted (always 1) |
| frac_word | input | 24 | Fraction numerator over 2^24 |
| mod_valid | output | 1 | Offset output holds a computed value |
| mod_ready | input | 1 | Consumer takes the offset; advances the modulator |
| mod_off | output | 4 | Signed modulus offset, −3..+4 |

## Verification
Two functions can fall in the same cycle: a fraction load, and either an advance or a stall on the output side. The random phase drives `frac_valid` and `mod_ready` independently, so loads land on advancing edges as well as inside stalls. A directed case loads a word during a stall and then releases it. A reference model applies the new word one advance later and checks every offset. During each stalled cycle it also confirms that the held offset has not changed.

// File: rtl/mash_pkg.sv
package mash_pkg;
  localparam int OFF_W  = 4;
  localparam int NSTAGE = 3;
  typedef logic [OFF_W-1:0] moff_t;
endpackage

// File: rtl/mash_accum.sv
module mash_accum #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic [W-1:0] addend,
  output logic [W-1:0] sum_o,
  output logic         carry_o
);
  logic [W-1:0] acc_q;
  logic [W:0]   total;

  always_comb begin
    total   = {1'b0, acc_q} + {1'b0, addend};
    sum_o   = total[W-1:0];
    carry_o = total[W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   acc_q <= '0;
    else if (adv) acc_q <= sum_o;
  end

  // R7
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(acc_q));
endmodule

// File: rtl/mash_noise_cancel.sv
module mash_noise_cancel
  import mash_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  input  logic  c1,
  input  logic  c2,
  input  logic  c3,
  output moff_t y_o,
  output logic  y_valid_o
);
  logic  c2_d1, c3_d1, c3_d2;
  moff_t y_next;

  always_comb begin
    y_next = OFF_W'(c1) + OFF_W'(c2) - OFF_W'(c2_d1)
           + OFF_W'(c3) - OFF_W'({c3_d1, 1'b0}) + OFF_W'(c3_d2);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c2_d1     <= 1'b0;
      c3_d1     <= 1'b0;
      c3_d2     <= 1'b0;
      y_o       <= '0;
      y_valid_o <= 1'b0;
    end else if (adv) begin
      c2_d1     <= c2;
      c3_d1     <= c3;
      c3_d2     <= c3_d1;
      y_o       <= y_next;
      y_valid_o <= 1'b1;
    end
  end

  // R3
  off_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((y_o >= 4'd5) && (y_o <= 4'd12)));

  // R7
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(y_o));

  // R8
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    y_valid_o |=> y_valid_o);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (y_o == '0 && !y_valid_o));
endmodule

// File: rtl/mash111_trunc.sv
module mash111_trunc
  import mash_pkg::*;
#(
  parameter int FRAC_W  = 24,
  parameter int MID_W   = 16,
  parameter int LAST_W  = 8,
  parameter bit CLK_NEG = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frac_valid,
  output logic              frac_ready,
  input  logic [FRAC_W-1:0] frac_word,
  output logic              mod_valid,
  input  logic              mod_ready,
  output logic [3:0]        mod_off
);
  localparam int SW [NSTAGE] = '{FRAC_W, MID_W, LAST_W};

  logic              mclk;
  logic              adv;
  logic [FRAC_W-1:0] frac_q;
  logic [FRAC_W-1:0] sum_a   [NSTAGE];
  logic [FRAC_W-1:0] addend_a[NSTAGE];
  logic [NSTAGE-1:0] carry;
  moff_t             y;

  generate
    if (CLK_NEG) begin : g_negedge
      assign mclk = ~clk;
    end else begin : g_posedge
      assign mclk = clk;
    end
  endgenerate

  assign frac_ready = 1'b1;
  assign adv        = mod_ready;

  always_ff @(posedge mclk) begin
    if (!rst_n)          frac_q <= '0;
    else if (frac_valid) frac_q <= frac_word;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NSTAGE; gi++) begin : g_stage
      logic [SW[gi]-1:0] st_sum;
      if (gi == 0) begin : g_first
        assign addend_a[gi] = frac_q;
      end else begin : g_next
        assign addend_a[gi] = FRAC_W'(sum_a[gi-1][SW[gi-1]-1 -: SW[gi]]);
      end
      mash_accum #(.W(SW[gi])) u_acc (
        .clk     (mclk),
        .rst_n   (rst_n),
        .adv     (adv),
        .addend  (addend_a[gi][SW[gi]-1:0]),
        .sum_o   (st_sum),
        .carry_o (carry[gi])
      );
      assign sum_a[gi] = FRAC_W'(st_sum);
    end
  endgenerate

  mash_noise_cancel u_cancel (
    .clk       (mclk),
    .rst_n     (rst_n),
    .adv       (adv),
    .c1        (carry[0]),
    .c2        (carry[1]),
    .c3        (carry[2]),
    .y_o       (y),
    .y_valid_o (mod_valid)
  );

  assign mod_off = y;

  // R2
  frac_take_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    frac_valid |=> frac_q == $past(frac_word));

  // R9
  frac_keep_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    !frac_valid |=> $stable(frac_q));
endmodule

// File: tb/tb_mash111_trunc.sv
module tb_mash111_trunc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frac_valid = 1'b0;
  logic        frac_ready;
  logic [23:0] frac_word = '0;
  logic        mod_valid;
  logic        mod_ready = 1'b0;
  logic [3:0]  mod_off;

  int checks = 0;
  int errors = 0;

  logic [23:0] m_frac, m_a1;
  logic [15:0] m_a2;
  logic [7:0]  m_a3;
  logic        m_c2d, m_c3d, m_c3dd, m_v;
  logic [3:0]  m_y;

  always #2 clk = ~clk;

  mash111_trunc dut (
    .clk(clk), .rst_n(rst_n), .frac_valid(frac_valid), .frac_ready(frac_ready),
    .frac_word(frac_word), .mod_valid(mod_valid), .mod_ready(mod_ready),
    .mod_off(mod_off)
  );

  function automatic logic [3:0] combine(logic c1, logic c2, logic c2d,
                                         logic c3, logic c3d, logic c3dd);
    int v;
    v = int'(c1) + int'(c2) - int'(c2d) + int'(c3) - 2 * int'(c3d) + int'(c3dd);
    return 4'(v);
  endfunction

  function automatic int to_signed4(logic [3:0] x);
    return x[3] ? int'(x) - 16 : int'(x);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_frac = '0; m_a1 = '0; m_a2 = '0; m_a3 = '0;
    m_c2d = 0; m_c3d = 0; m_c3dd = 0; m_y = '0; m_v = 0;
  endtask

  task automatic model_adv();
    logic [24:0] s1;
    logic [16:0] s2;
    logic [8:0]  s3;
    s1 = {1'b0, m_a1} + {1'b0, m_frac};
    s2 = {1'b0, m_a2} + {1'b0, s1[23:8]};
    s3 = {1'b0, m_a3} + {1'b0, s2[15:8]};
    m_y = combine(s1[24], s2[16], m_c2d, s3[8], m_c3d, m_c3dd);
    m_c2d = s2[16]; m_c3dd = m_c3d; m_c3d = s3[8];
    m_a1 = s1[23:0]; m_a2 = s2[15:0]; m_a3 = s3[7:0];
    m_v = 1;
  endtask

  // Called at a negedge; drives one edge and checks after it.
  task automatic step(bit fv, logic [23:0] fw, bit rdy, string req);
    logic [3:0] prev;
    prev = mod_off;
    frac_valid = fv; frac_word = fw; mod_ready = rdy;
    if (rdy) model_adv();
    if (fv) m_frac = fw;
    @(posedge clk);
    @(negedge clk);
    check(req, mod_off, m_y);
    check("R8", mod_valid, m_v);
    check("R2", frac_ready, 1'b1);
    if (!rdy) check("R7", mod_off, prev);
    if (mod_off >= 4'd5 && mod_off <= 4'd12) check("R3", mod_off, 4'd0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; mod_ready = 0; frac_valid = 0;
    repeat (3) @(negedge clk);
    model_reset();
    check("R1", mod_off, 4'd0);
    check("R1", mod_valid, 1'b0);
    rst_n = 1;
  endtask

  task automatic mean_test(logic [23:0] f);
    longint sum;
    longint diff;
    do_reset();
    step(1, f, 0, "R2");
    sum = 0;
    for (int i = 0; i < 4096; i++) begin
      step(0, '0, 1, "R4");
      sum += to_signed4(mod_off);
    end
    diff = sum * 4096 - longint'(f);
    if (diff < 0) diff = -diff;
    checks++;
    if (diff > 65536) begin
      errors++;
      $display("FAIL R6 actual_sum=%0d expected_mean=%0d/2^24", sum, f);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    do_reset();

    // R5: zero fraction gives zero offsets; R8 first advance sets valid
    for (int i = 0; i < 40; i++) step(0, '0, 1, "R5");

    // R4 directed corner fractions
    step(1, 24'hFFFFFF, 1, "R4");
    for (int i = 0; i < 200; i++) step(0, '0, 1, "R4");
    step(1, 24'h800000, 1, "R4");
    for (int i = 0; i < 200; i++) step(0, '0, 1, "R4");
    step(1, 24'h000001, 1, "R4");
    for (int i = 0; i < 200; i++) step(0, '0, 1, "R4");

    // R9: load during a stall, then resume
    step(0, '0, 0, "R7");
    step(1, 24'h3A5C11, 0, "R9");
    step(0, '0, 0, "R7");
    for (int i = 0; i < 20; i++) step(0, '0, 1, "R9");

    // random mix of loads, stalls and advances (R4, R7, R9)
    for (int i = 0; i < 3000; i++) begin
      bit fv, rdy;
      fv  = ($urandom % 8) == 0;
      rdy = ($urandom % 4) != 0;
      step(fv, 24'($urandom), rdy, "R4");
    end

    // R1 mid-run reset
    do_reset();
    for (int i = 0; i < 10; i++) step(0, '0, 1, "R1");

    // R6 running mean
    mean_test(24'h155555);
    mean_test(24'hF00001);
    mean_test(24'($urandom));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule